// File: doc/BRIEF.md
# Framed Link Alarm Monitor

This block sits beside a SONET/SDH framer and turns its raw status into a compact status word for software. Two of the framer outputs are levels: one says the receiver has no usable optical signal, and the other says the overhead processor has lost alignment to the frame stream. Five more are single-cycle event pulses, one each for section parity, line parity, line far-end error, path parity and path far-end error. Every indicator is held as "has happened since the last read". A read strobe returns the held word and clears it.

A loss-of-frame alarm is derived inside the block. It is raised when out-of-frame has stayed asserted for longer than a time threshold. The threshold is a parameter counted in clock cycles, and the default equals 3 ms at a 77.76 MHz clock. A small state machine runs the timer. Its states are CLEAR (aligned), COUNT (out of frame, timing the run) and ALARM (threshold exceeded). The transitions are: CLEAR to COUNT when out-of-frame is seen; COUNT to CLEAR when out-of-frame drops, which also restarts the timer; COUNT to ALARM when out-of-frame is still high after the counter reaches the threshold; ALARM to CLEAR when out-of-frame drops. The live alarm is also driven out of the block directly.

Top module: `lam_link_alarm_monitor`

## Requirements
- R1: After reset, `status_o` is all zero and `frame_loss_o` is low.
- R2: Bit 0 of `status_o` is set one cycle after `los_i` is sampled high.
- R3: Bit 1 of `status_o` is set one cycle after `oof_i` is sampled high.
- R4: `frame_loss_o` goes high on the clock edge at which `oof_i` has been sampled high on LOF_CYCLES+1 consecutive edges. Bit 2 of `status_o` is set on the following edge.
- R5: A single edge with `oof_i` low restarts the timer and drops `frame_loss_o` on that edge. A later run of `oof_i` needs the full LOF_CYCLES+1 edges again before the alarm returns.
- R6: The event pulses map to these bits: section parity to bit 3, line parity to bit 4, line far-end error to bit 5, path parity to bit 6, path far-end error to bit 7.
- R7: A set bit stays set, with no read, after its cause goes away.
- R8: In a cycle where `rd_stb_i` is high, `status_o` holds the value being read. On the following edge, every bit whose cause is not active in the read cycle is cleared.
- R9: An event pulse that arrives in the same cycle as the read is kept set after the read.
- R10: A level condition (loss of signal, out of frame, loss of frame) that is still active during the read leaves its bit set after the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| los_i | input | 1 | Level: no usable optical signal |
| oof_i | input | 1 | Level: not aligned to frame stream |
| sect_par_err_i | input | 1 | Pulse: section parity error |
| line_par_err_i | input | 1 | Pulse: line parity error |
| line_rem_err_i | input | 1 | Pulse: line far-end error |
| path_par_err_i | input | 1 | Pulse: path parity error |
| path_rem_err_i | input | 1 | Pulse: path far-end error |
| rd_stb_i | input | 1 | Read strobe: return and clear the status word |
| status_o | output | 8 | Sticky status word |
| frame_loss_o | output | 1 | Live loss-of-frame alarm |

## Verification
The functions most likely to collide are the clear-on-read and the setting of a bit, because an event pulse or a still-active level can land in the very cycle the read strobe is high. Directed cases place a parity pulse on the read cycle and hold loss of signal across a read. The bench then checks that only the untouched bits clear. A second collision is the alarm rising while a read is underway. Long random runs mix both with out-of-frame bursts near the threshold, and every cycle is compared with a bench model built from the requirements.

// File: rtl/lam_pkg.sv
package lam_pkg;

    localparam int unsigned STAT_W       = 8;
    localparam int unsigned NUM_EVT      = 5;

    localparam int unsigned BIT_LOS      = 0;
    localparam int unsigned BIT_OOF      = 1;
    localparam int unsigned BIT_LOF      = 2;
    localparam int unsigned BIT_SECT_PAR = 3;
    localparam int unsigned BIT_LINE_PAR = 4;
    localparam int unsigned BIT_LINE_REM = 5;
    localparam int unsigned BIT_PATH_PAR = 6;
    localparam int unsigned BIT_PATH_REM = 7;

    typedef enum logic [1:0] {
        LT_CLEAR = 2'd0,
        LT_COUNT = 2'd1,
        LT_ALARM = 2'd2
    } lof_state_e;

endpackage

// File: rtl/lam_frame_loss_timer.sv
module lam_frame_loss_timer
    import lam_pkg::*;
#(
    parameter int unsigned LOF_CYCLES = 233280
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oof_i,
    output logic lof_o
);

    localparam int unsigned CW    = $clog2(LOF_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOF_CYCLES);
    localparam logic [CW-1:0] ONE   = CW'(1);

    lof_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // next-state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            LT_CLEAR: begin
                if (oof_i) begin
                    state_d = LT_COUNT;
                    cnt_d   = ONE;
                end else begin
                    cnt_d   = '0;
                end
            end
            LT_COUNT: begin
                if (!oof_i) begin
                    state_d = LT_CLEAR;
                    cnt_d   = '0;
                end else if (cnt_q == LIMIT) begin
                    state_d = LT_ALARM;
                end else begin
                    cnt_d   = cnt_q + ONE;
                end
            end
            LT_ALARM: begin
                if (!oof_i) begin
                    state_d = LT_CLEAR;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = LT_CLEAR;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LT_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        lof_o = (state_q == LT_ALARM);
    end

    p_lof_needs_full_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lof_o) |-> ($past(oof_i) && ($past(cnt_q) == LIMIT)));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    p_lof_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !oof_i |=> (!lof_o && cnt_q == '0));

endmodule

// File: rtl/lam_sticky_bits.sv
module lam_sticky_bits #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         rd_i,
    output logic [W-1:0] q_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_o[i] <= 1'b0;
            end else if (rd_i) begin
                q_o[i] <= set_i[i];
            end else if (set_i[i]) begin
                q_o[i] <= 1'b1;
            end
        end

        p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (q_o[i] && !rd_i) |=> q_o[i]);

        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]);

        p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_i && !set_i[i]) |=> !q_o[i]);
    end

endmodule

// File: rtl/lam_link_alarm_monitor.sv
module lam_link_alarm_monitor
    import lam_pkg::*;
#(
    parameter int unsigned LOF_CYCLES = 233280
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              los_i,
    input  logic              oof_i,
    input  logic              sect_par_err_i,
    input  logic              line_par_err_i,
    input  logic              line_rem_err_i,
    input  logic              path_par_err_i,
    input  logic              path_rem_err_i,
    input  logic              rd_stb_i,
    output logic [STAT_W-1:0] status_o,
    output logic              frame_loss_o
);

    logic              lof;
    logic [STAT_W-1:0] set_vec;

    lam_frame_loss_timer #(
        .LOF_CYCLES (LOF_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .oof_i (oof_i),
        .lof_o (lof)
    );

    // gather set causes into register order
    always_comb begin
        set_vec               = '0;
        set_vec[BIT_LOS]      = los_i;
        set_vec[BIT_OOF]      = oof_i;
        set_vec[BIT_LOF]      = lof;
        set_vec[BIT_SECT_PAR] = sect_par_err_i;
        set_vec[BIT_LINE_PAR] = line_par_err_i;
        set_vec[BIT_LINE_REM] = line_rem_err_i;
        set_vec[BIT_PATH_PAR] = path_par_err_i;
        set_vec[BIT_PATH_REM] = path_rem_err_i;
    end

    lam_sticky_bits #(
        .W (STAT_W)
    ) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .rd_i  (rd_stb_i),
        .q_o   (status_o)
    );

    assign frame_loss_o = lof;

    p_rd_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_i |=> ((status_o & ~$past(set_vec)) == '0));

    p_lof_bit_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_loss_o |=> status_o[BIT_LOF]);

    p_los_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        los_i |=> status_o[BIT_LOS]);

    p_oof_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oof_i |=> status_o[BIT_OOF]);

endmodule

// File: tb/lam_link_alarm_monitor_bench.sv
module lam_link_alarm_monitor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       los = 1'b0, oof = 1'b0, rd = 1'b0;
    logic [4:0] ev = '0;
    logic [7:0] status;
    logic       floss;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lam_link_alarm_monitor #(.LOF_CYCLES(N)) u_lam_link_alarm_monitor (
        .clk            (clk),
        .rst_n          (rst_n),
        .los_i          (los),
        .oof_i          (oof),
        .sect_par_err_i (ev[0]),
        .line_par_err_i (ev[1]),
        .line_rem_err_i (ev[2]),
        .path_par_err_i (ev[3]),
        .path_rem_err_i (ev[4]),
        .rd_stb_i       (rd),
        .status_o       (status),
        .frame_loss_o   (floss)
    );

    // reference model built from the requirements
    logic [7:0] exp_st  = '0;
    logic       exp_lof = 1'b0;
    int         run     = 0;

    function automatic logic [7:0] next_status(input logic [7:0] cur, input logic [7:0] setv,
                                               input logic rdv);
        return rdv ? setv : (cur | setv);
    endfunction

    always @(posedge clk) begin
        int rn;
        if (!rst_n) begin
            exp_st  <= '0;
            exp_lof <= 1'b0;
            run     <= 0;
        end else begin
            rn = oof ? ((run > N) ? run : run + 1) : 0;
            exp_st  <= next_status(exp_st, {ev, exp_lof, oof, los}, rd);
            run     <= rn;
            exp_lof <= (rn > N);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycles=%0d expected under 200000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic cyc(input logic l, input logic o, input logic [4:0] e, input logic r);
        los = l; oof = o; ev = e; rd = r;
        @(negedge clk);
        los = 1'b0; ev = '0; rd = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk8("R1 reset status", status, 8'h00);
        chk1("R1 reset alarm", floss, 1'b0);

        // R6 bit mapping, R7 hold, R8 read value and clear
        for (int i = 0; i < 5; i++) begin
            cyc(1'b0, 1'b0, 5'(1 << i), 1'b0);
            chk8("R6 event bit position", status, 8'(1 << (3 + i)));
            cyc(1'b0, 1'b0, '0, 1'b0);
            chk8("R7 event bit held", status, 8'(1 << (3 + i)));
            chk8("R8 value presented on read", status, 8'(1 << (3 + i)));
            cyc(1'b0, 1'b0, '0, 1'b1);
            chk8("R8 cleared after read", status, 8'h00);
        end

        // R9 pulse coincident with read
        cyc(1'b0, 1'b0, 5'b00001, 1'b0);
        cyc(1'b0, 1'b0, 5'b00010, 1'b1);
        chk8("R9 coincident pulse kept", status, 8'h10);
        cyc(1'b0, 1'b0, '0, 1'b1);
        chk8("R8 clear after coincident", status, 8'h00);

        // R2 and R10 loss of signal level
        cyc(1'b1, 1'b0, '0, 1'b0);
        chk8("R2 los bit", status, 8'h01);
        cyc(1'b1, 1'b0, '0, 1'b1);
        chk8("R10 active level kept over read", status, 8'h01);
        cyc(1'b0, 1'b0, '0, 1'b0);
        chk8("R7 los bit held after drop", status, 8'h01);
        cyc(1'b0, 1'b0, '0, 1'b1);
        chk8("R8 los cleared", status, 8'h00);

        // R3 and R5: short run, drop, then threshold
        for (int k = 0; k < N; k++) cyc(1'b0, 1'b1, '0, 1'b0);
        chk1("R5 no alarm before threshold", floss, 1'b0);
        chk8("R3 oof bit", status, 8'h02);
        cyc(1'b0, 1'b0, '0, 1'b0);
        for (int k = 0; k < N; k++) cyc(1'b0, 1'b1, '0, 1'b0);
        chk1("R5 timer restarted after drop", floss, 1'b0);
        cyc(1'b0, 1'b1, '0, 1'b0);
        chk1("R4 alarm at threshold plus one", floss, 1'b1);
        chk8("R4 lof bit not yet", status, 8'h02);
        cyc(1'b0, 1'b1, '0, 1'b1);
        chk8("R10 lof and oof kept over read", status, 8'h06);
        cyc(1'b0, 1'b0, '0, 1'b0);
        chk1("R5 alarm drops with oof", floss, 1'b0);
        chk8("R7 lof bit held", status, 8'h06);
        cyc(1'b0, 1'b0, '0, 1'b1);
        chk8("R8 all cleared", status, 8'h00);

        // random mix checked against the model each cycle (R4 R7 R8 R9 R10)
        for (int c = 0; c < 6000; c++) begin
            if ($urandom_range(19) == 0) oof = ~oof;
            if ($urandom_range(29) == 0) los = ~los;
            for (int b = 0; b < 5; b++) ev[b] = ($urandom_range(7) == 0);
            rd = ($urandom_range(5) == 0);
            @(negedge clk);
            chk8("R7/R9 random status", status, exp_st);
            chk1("R4 random alarm", floss, exp_lof);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule